// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block is the synthesizable front end of a behavioural DRAM device model. The active-low row strobe, column strobe and write enable are sampled on a system clock. From the order in which they move, each memory cycle is classified as one of five kinds:

- a column read;
- a column write;
- a refresh that uses only the row strobe;
- a refresh in which the column strobe leads the row strobe;
- a test mode entry, where the column strobe and write enable both lead the row strobe.

Each classification produces a one-cycle pulse on its own output.

A sticky test mode flag is set by the entry cycle. It holds through any number of ordinary accesses. Either kind of refresh clears it. While the flag is set, the lowest column address bit is ignored: each access covers a pair of bit cells. A write stores the data bit into both cells of the pair. A read returns 1 when the two cells agree and 0 when they differ. A small bit array on chip holds the stored data, so the whole behaviour can be observed at the pins. The address is multiplexed: the row is taken when the row strobe falls, and the column is taken when the column strobe falls.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, every cycle pulse, `test_mode`, `dout` and `dout_valid` are 0.
- R2: If the row strobe is first sampled low while the column strobe is low and write enable is high, `cbr_pulse` is high for exactly the one cycle after that sampling edge.
- R3: If the row strobe is first sampled low while the column strobe and write enable are both low, `tm_entry_pulse` is high for the one cycle after that sampling edge, and `test_mode` reads 1 from that same cycle.
- R4: A row cycle starts with the column strobe high. If the row strobe is then sampled high again without any column strobe fall in between, `ror_pulse` is high for the one cycle after that sampling edge.
- R5: A column strobe fall during a row cycle is a write when write enable is low and a read when it is high. It produces `wr_pulse` or `rd_pulse` in the next cycle. Cell addressing: the cell index is {row, column}, with the row in the upper AW bits. Outside test mode, a write stores `din` into that cell. A read raises `dout_valid` with `dout` equal to the stored bit, in the same cycle as `rd_pulse`.
- R6: Once set, `test_mode` stays 1 across any number of read and write cycles.
- R7: A refresh of either kind clears `test_mode`. It reads 0 in the same cycle as `cbr_pulse` or `ror_pulse`.
- R8: In test mode, a write stores `din` into both cells {row, col with bit 0 = 0} and {row, col with bit 0 = 1}.
- R9: In test mode, a read returns `dout` = 1 when the two cells of the pair hold equal bits and 0 otherwise. Column bit 0 has no effect on the result.
- R10: At most one cycle pulse is high in any cycle, and each pulse lasts one cycle.
- R11: Several column strobe falls within one low period of the row strobe each produce their own access, all on the row latched at the row strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data, or the pair-compare result in test mode |
| dout_valid | output | 1 | `dout` updated by a read |
| rd_pulse | output | 1 | Read cycle seen |
| wr_pulse | output | 1 | Write cycle seen |
| ror_pulse | output | 1 | Row-only refresh seen |
| cbr_pulse | output | 1 | Column-first refresh seen |
| tm_entry_pulse | output | 1 | Test mode entry seen |
| test_mode | output | 1 | Latched test mode flag |

## Verification
The bench builds the block with the default AW = 3. This gives 8 rows by 8 columns, a 64-cell array. Every column pair of a row is therefore reachable within a short run. With this size the bench can prepare a pair with unequal contents and a pair with equal contents, and read each through either column of the pair. A reference model of the array kept in the bench follows every normal and test-mode write. Those reads show both compare outcomes and confirm that column bit 0 is ignored.

// File: rtl/dram_cd_pkg.sv
// Package: types shared by the cycle decoder blocks.
// The five cycle kinds are carried together as one packed event set.
package dram_cd_pkg;

    typedef struct packed {
        logic rd;   // column read
        logic wr;   // column write
        logic ror;  // refresh using only the row strobe
        logic cbr;  // refresh with the column strobe leading
        logic tme;  // test mode entry
    } cyc_ev_t;

endpackage

// File: rtl/dram_cd_classifier.sv
// Module: dram_cd_classifier
// Samples the three strobes on clk and classifies the cycle from the order of their edges.
// It produces combinational events at the sampling edge and registered one-cycle pulses after it.
// Assumes the strobes are already synchronous to clk. Idle value of every strobe is high.
module dram_cd_classifier
    import dram_cd_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output cyc_ev_t       ev,
    output cyc_ev_t       pulse,
    output logic [AW-1:0] row_q
);

    logic ras_q, cas_q;   // strobes at the previous edge
    logic in_row;         // row cycle open (row strobe fell with column strobe high)
    logic saw_col;        // a column access happened in this row cycle
    logic ras_fall, cas_fall;

    assign ras_fall = ras_q & ~ras_n;
    assign cas_fall = cas_q & ~cas_n;

    // Decode the events of the current sampling edge.
    always_comb begin
        ev     = '0;
        ev.tme = ras_fall & ~cas_n & ~we_n;
        ev.cbr = ras_fall & ~cas_n & we_n;
        ev.ror = in_row & ras_n & ~saw_col;
        ev.rd  = in_row & ~ras_n & cas_fall & we_n;
        ev.wr  = in_row & ~ras_n & cas_fall & ~we_n;
    end

    // Remember the strobe history and the state of the open row cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q   <= 1'b1;
            cas_q   <= 1'b1;
            in_row  <= 1'b0;
            saw_col <= 1'b0;
            row_q   <= '0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            if (ras_fall && cas_n) begin
                in_row  <= 1'b1;
                saw_col <= 1'b0;
                row_q   <= addr;
            end else if (ras_n) begin
                in_row  <= 1'b0;
                saw_col <= 1'b0;
            end else if (ev.rd || ev.wr) begin
                saw_col <= 1'b1;
            end
        end
    end

    // Register the events into one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= '0;
        else        pulse <= ev;
    end

endmodule

// File: rtl/dram_cd_mode_latch.sv
// Module: dram_cd_mode_latch
// Holds the sticky test mode flag. An entry event sets it and either refresh event clears it.
// Assumes the entry and refresh events never coincide, which the classifier guarantees.
module dram_cd_mode_latch
    import dram_cd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cyc_ev_t ev,
    output logic    tmode
);

    // Set on entry, clear on any refresh, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                tmode <= 1'b0;
        else if (ev.cbr || ev.ror) tmode <= 1'b0;
        else if (ev.tme)           tmode <= 1'b1;
    end

endmodule

// File: rtl/dram_cd_bit_array.sv
// Module: dram_cd_bit_array
// Bit-cell storage, indexed by {row, col}.
// In test mode a write covers both cells of a column pair, and a read returns the equality of that pair.
// Assumes at most one of rd/wr in any cycle. Contents are cleared by reset.
module dram_cd_bit_array #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          wr,
    input  logic          tmode,
    input  logic [AW-1:0] row,
    input  logic [AW-1:0] col,
    input  logic          din,
    output logic          dout,
    output logic          dout_valid
);

    localparam int IW    = 2 * AW;
    localparam int DEPTH = 1 << IW;

    logic [DEPTH-1:0] mem;
    logic [IW-1:0]    idx, idx_lo, idx_hi;

    assign idx    = {row, col};
    assign idx_lo = {row, col[AW-1:1], 1'b0};
    assign idx_hi = {row, col[AW-1:1], 1'b1};

    // Store the write bit in one cell, or in both cells of the pair in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr) begin
            if (tmode) begin
                mem[idx_lo] <= din;
                mem[idx_hi] <= din;
            end else begin
                mem[idx] <= din;
            end
        end
    end

    // Return the stored bit, or the pair compare result in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= 1'b0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= rd;
            if (rd) dout <= tmode ? (mem[idx_lo] == mem[idx_hi]) : mem[idx];
        end
    end

endmodule

// File: rtl/dram_cycle_decoder.sv
// Module: dram_cycle_decoder (top)
// Classifies strobe cycles, latches the test mode flag and serves accesses from the bit array.
// Assumes strobes synchronous to clk. The column is taken from addr at the column strobe fall.
module dram_cycle_decoder
    import dram_cd_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          dout,
    output logic          dout_valid,
    output logic          rd_pulse,
    output logic          wr_pulse,
    output logic          ror_pulse,
    output logic          cbr_pulse,
    output logic          tm_entry_pulse,
    output logic          test_mode
);

    cyc_ev_t       ev, pulse;
    logic [AW-1:0] row_q;

    dram_cd_classifier #(.AW(AW)) u_cls (
        .clk   (clk),
        .rst_n (rst_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr),
        .ev    (ev),
        .pulse (pulse),
        .row_q (row_q)
    );

    dram_cd_mode_latch u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .tmode (test_mode)
    );

    dram_cd_bit_array #(.AW(AW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (ev.rd),
        .wr         (ev.wr),
        .tmode      (test_mode),
        .row        (row_q),
        .col        (addr),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    assign rd_pulse       = pulse.rd;
    assign wr_pulse       = pulse.wr;
    assign ror_pulse      = pulse.ror;
    assign cbr_pulse      = pulse.cbr;
    assign tm_entry_pulse = pulse.tme;

endmodule

// File: rtl/dram_cycle_decoder_chk.sv
// Module: dram_cycle_decoder_chk
// Port-level properties of the cycle decoder. Attached to every instance of the top through bind.
module dram_cycle_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dout_valid,
    input logic rd_pulse,
    input logic wr_pulse,
    input logic ror_pulse,
    input logic cbr_pulse,
    input logic tm_entry_pulse,
    input logic test_mode
);

    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_pulse, wr_pulse, ror_pulse, cbr_pulse, tm_entry_pulse}));

    a_r2_cbr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cbr_pulse |-> $past(!ras_n && !cas_n && we_n));

    a_r2_cbr_single: assert property (@(posedge clk) disable iff (!rst_n)
        cbr_pulse |=> !cbr_pulse);

    a_r3_entry_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tm_entry_pulse |-> test_mode);

    a_r4_ror_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ror_pulse |-> $past(ras_n));

    a_r5_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |-> dout_valid);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(test_mode) && !cbr_pulse && !ror_pulse) |-> test_mode);

    a_r7_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_pulse || ror_pulse) |-> !test_mode);

endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk u_chk (.*);

// File: tb/dram_cycle_decoder_bench.sv
// Scoreboard bench: the driver pushes the expected events, and a monitor pops and compares them.
module dram_cycle_decoder_bench;

    localparam int AW = 3;

    typedef struct {
        logic [4:0] vec;   // {rd, wr, ror, cbr, tme}
        logic       tm;
        logic       is_rd;
        logic       dv;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [AW-1:0] addr = '0;
    logic dout, dout_valid, rd_pulse, wr_pulse, ror_pulse, cbr_pulse, tm_entry_pulse, test_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mon_on = 0;
    exp_t q[$];
    bit model [1 << (2*AW)];
    bit tm_model = 0;

    always #2 clk = ~clk;

    dram_cycle_decoder #(.AW(AW)) u_dram_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid),
        .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .ror_pulse(ror_pulse),
        .cbr_pulse(cbr_pulse), .tm_entry_pulse(tm_entry_pulse), .test_mode(test_mode)
    );

    task automatic step(input logic r, input logic c, input logic w,
                        input logic [AW-1:0] a, input logic d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; addr = a; din = d;
    endtask

    task automatic push(input logic [4:0] v, input logic isr, input logic dv, input string tag);
        exp_t e;
        e.vec = v; e.tm = tm_model; e.is_rd = isr; e.dv = dv; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        step(1, 1, 1, '0, 0);
    endtask

    task automatic open_row(input logic [AW-1:0] row);
        idle();
        step(0, 1, 1, row, 0);
    endtask

    // Column access inside an open row. The CAS high step gives a fresh fall (R11).
    task automatic col_wr(input logic [AW-1:0] row, input logic [AW-1:0] col,
                          input logic d, input string tag);
        step(0, 0, 0, col, d);
        if (tm_model) begin
            model[{row, col[AW-1:1], 1'b0}] = d;
            model[{row, col[AW-1:1], 1'b1}] = d;
        end else begin
            model[{row, col}] = d;
        end
        push(5'b01000, 0, 0, tag);
        step(0, 1, 1, col, 0);
    endtask

    task automatic col_rd(input logic [AW-1:0] row, input logic [AW-1:0] col, input string tag);
        logic exp_d;
        step(0, 0, 1, col, 0);
        if (tm_model) exp_d = (model[{row, col[AW-1:1], 1'b0}] == model[{row, col[AW-1:1], 1'b1}]);
        else          exp_d = model[{row, col}];
        push(5'b10000, 1, exp_d, tag);
        step(0, 1, 1, col, 0);
    endtask

    task automatic close_row();
        idle();
    endtask

    task automatic cas_first(input logic w, input string tag);
        idle();
        step(1, 0, w, '0, 0);
        step(0, 0, w, '0, 0);
        if (w) begin
            tm_model = 0;
            push(5'b00010, 0, 0, tag);
        end else begin
            tm_model = 1;
            push(5'b00001, 0, 0, tag);
        end
        step(0, 0, 1, '0, 0);
        step(1, 0, 1, '0, 0);
        idle();
    endtask

    task automatic row_only(input logic [AW-1:0] row, input string tag);
        open_row(row);
        step(0, 1, 1, row, 0);
        step(1, 1, 1, '0, 0);
        tm_model = 0;
        push(5'b00100, 0, 0, tag);
        idle();
    endtask

    // Monitor: every pulse must match the next expected item (R10 one-hot, exact vector).
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && ({rd_pulse, wr_pulse, ror_pulse, cbr_pulse, tm_entry_pulse} != 5'b0)) begin
                checks++;
                if (q.size() == 0) begin
                    failures++;
                    $display("FAIL unexpected pulse R10: actual=%b expected=none",
                             {rd_pulse, wr_pulse, ror_pulse, cbr_pulse, tm_entry_pulse});
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if ({rd_pulse, wr_pulse, ror_pulse, cbr_pulse, tm_entry_pulse} != e.vec ||
                        test_mode != e.tm ||
                        (e.is_rd && (dout !== e.dv || dout_valid !== 1'b1))) begin
                        failures++;
                        $display("FAIL %s: actual vec=%b tm=%b dout=%b dv=%b expected vec=%b tm=%b dout=%b",
                                 e.tag, {rd_pulse, wr_pulse, ror_pulse, cbr_pulse, tm_entry_pulse},
                                 test_mode, dout, dout_valid, e.vec, e.tm, e.dv);
                    end
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if ({dout, dout_valid, rd_pulse, wr_pulse, ror_pulse, cbr_pulse, tm_entry_pulse, test_mode} != 8'b0) begin
            failures++;
            $display("FAIL R1: actual=%b expected=00000000",
                     {dout, dout_valid, rd_pulse, wr_pulse, ror_pulse, cbr_pulse, tm_entry_pulse, test_mode});
        end
        mon_on = 1;

        // R5, R11: normal writes and reads, several in one row cycle
        open_row(3'd1);
        col_wr(3'd1, 3'd2, 1, "R5_wr_r1c2");
        col_wr(3'd1, 3'd3, 0, "R11_wr_r1c3");
        col_wr(3'd1, 3'd5, 1, "R11_wr_r1c5");
        close_row();
        open_row(3'd1);
        col_rd(3'd1, 3'd2, "R5_rd_r1c2");
        col_rd(3'd1, 3'd3, "R11_rd_r1c3");
        col_rd(3'd1, 3'd5, "R11_rd_r1c5");
        close_row();

        cas_first(1, "R2_cbr");
        row_only(3'd4, "R4_ror");
        cas_first(0, "R3_entry");

        // R9: unequal pair, either column of it; R6: flag holds through accesses
        open_row(3'd1);
        col_rd(3'd1, 3'd2, "R9_rd_pair_diff_c2");
        col_rd(3'd1, 3'd3, "R9_rd_pair_diff_c3");
        col_rd(3'd1, 3'd4, "R9_rd_pair_c4c5");
        close_row();
        // R8: test write fills the pair
        open_row(3'd2);
        col_wr(3'd2, 3'd4, 1, "R8_tm_wr");
        col_rd(3'd2, 3'd5, "R9_rd_pair_equal");
        close_row();
        open_row(3'd2);
        col_rd(3'd2, 3'd4, "R6_still_test");
        close_row();

        // R7: exit by row-only refresh, then check both cells in normal mode (R8)
        row_only(3'd0, "R7_exit_ror");
        open_row(3'd2);
        col_rd(3'd2, 3'd4, "R8_cell_lo");
        col_rd(3'd2, 3'd5, "R8_cell_hi");
        close_row();

        // R7: exit by column-first refresh
        cas_first(0, "R3_entry2");
        cas_first(1, "R7_exit_cbr");
        open_row(3'd1);
        col_rd(3'd1, 3'd3, "R7_normal_after_exit");
        close_row();

        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R10 missing pulses: actual=%0d expected=0", q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule